// File: doc/BRIEF.md
# Four-Channel Legacy DMA Channel Controller

This block is a four-channel DMA sequencer in the classic personal-computer style. Software programs it through a small 8-bit I/O port space. Each channel has a 16-bit transfer address and a 16-bit transfer count. Both are reached through one shared byte pointer, so two successive accesses to the same port form a 16-bit value. A channel also has an 8-bit page register and a mode byte, and each channel has its own mask bit.

Peripherals raise single-cycle request pulses, and the block latches them. Among the unmasked pending requests, fixed priority picks one channel for each cycle. The block then drives a one-cycle acknowledge for that channel, together with the 24-bit memory address, the transfer direction and a terminal-count flag. The page register never increments, so a transfer stays inside a 64K window, or a 128K window when the `WORD_MODE` parameter selects 16-bit transfers. Cascading, bus arbitration and the data movement itself are handled outside the block.

Port map, by `io_addr`:
- 0x00+2c: address of channel c.
- 0x01+2c: count of channel c.
- 0x08: status (read).
- 0x0A: single mask.
- 0x0B: mode.
- 0x0C: clear byte pointer.
- 0x0D: master clear.
- 0x0E: unmask all.
- 0x0F: write all masks.
- 0x10+c: page of channel c.

Top module: `isa_dma4_ctrl`

## Requirements
- R1: After reset all four mask bits are set, `dack`, `tc` and `mem_addr` are zero, the byte pointer selects the low byte and the status byte reads 0x00.
- R2: Accessing an address port (0x00+2c) or count port (0x01+2c), by read or by write, reaches the low byte when the pointer is low and the high byte when it is high, and toggles the pointer. A write loads both the base and the current register. A read returns the current value.
- R3: Any write to port 0x0C forces the byte pointer to the low byte, whatever the data.
- R4: A count register loaded with N gives N+1 transfers, and `tc` is high only with the acknowledge of the last one.
- R5: A write to port 0x0A selects a channel with data bits [1:0]. Bit 2 set masks that channel and bit 2 clear unmasks it. A masked channel receives no acknowledge.
- R6: A write to port 0x0F loads all four mask bits from data bits [3:0]. A write to port 0x0E clears all four.
- R7: A write to port 0x0B selects a channel with bits [1:0] and sets its mode. Bits [3:2] = 01 moves I/O to memory (`mem_wr`=1) and 10 moves memory to I/O (`mem_wr`=0). Bit 4 enables auto-initialise. Bits [7:6] = 11 is cascade: the request is acknowledged, the address and count stay unchanged and `tc` stays low.
- R8: In byte mode `mem_addr` is {page, current address}. The current address increments after each transfer and wraps from 0xFFFF to 0x0000 without changing the page.
- R9: In word mode `mem_addr` is {page[7:1], current address, 0}. Page bit 0 is ignored.
- R10: At terminal count the channel sets its status flag. Without auto-initialise it masks itself and its count reads back 0xFFFF.
- R11: With auto-initialise, terminal count reloads the current address and count from the base registers, and the channel stays unmasked.
- R12: A write to port 0x0D sets all mask bits, clears the byte pointer, the status flags and the pending requests, and keeps the programmed address and count values.
- R13: Simultaneous unmasked requests are granted one cycle each, lowest channel number first.
- R14: Status (port 0x08) reads {pending[3:0], tc flag[3:0]}. A status read clears the tc flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| io_addr | input | 5 | Register port index |
| io_wr | input | 1 | Register write strobe |
| io_rd | input | 1 | Register read strobe (advances the byte pointer and clears the status flags) |
| io_wdata | input | 8 | Register write data |
| io_rdata | output | 8 | Register read data, combinational |
| dreq | input | 4 | Single-cycle request pulses, one per channel |
| dack | output | 4 | One-hot acknowledge, one cycle per transfer |
| mem_addr | output | 24 | Memory address of the acknowledged transfer |
| mem_wr | output | 1 | 1 when the transfer writes memory (I/O to memory) |
| tc | output | 1 | Terminal count, high with the final acknowledge |

## Verification
A wrong byte pointer shows on the very next register read, because the bytes of a programmed address come back swapped. A wrong current address or page shows on `mem_addr` one cycle after the latched request, that is two clock edges after the `dreq` pulse. A count that is off by one moves `tc` to the wrong acknowledge, and a missing self-mask produces an extra acknowledge on the next request. Priority or pending-latch errors show as the wrong one-hot `dack` order in the cycles right after simultaneous requests.

// File: rtl/dma4_pkg.sv
`timescale 1ns/1ps
package dma4_pkg;
    localparam int NCH    = 4;
    localparam int CH_W   = $clog2(NCH);
    localparam int BYTE_W = 8;
    localparam int AREG_W = 16;
    localparam int PAGE_W = 8;
    localparam int PHYS_W = AREG_W + PAGE_W;
    localparam int PORT_W = 5;

    typedef enum logic [2:0] {
        OP_STAT       = 3'd0,
        OP_SPARE      = 3'd1,
        OP_SMASK      = 3'd2,
        OP_MODE       = 3'd3,
        OP_PTR_CLR    = 3'd4,
        OP_MCLR       = 3'd5,
        OP_UNMASK_ALL = 3'd6,
        OP_MASK_ALL   = 3'd7
    } ctl_op_e;

    localparam logic [1:0] DIR_IO2MEM = 2'b01;
    localparam logic [1:0] KIND_CASC  = 2'b11;

    typedef struct packed {
        logic [1:0] kind;
        logic       reload;
        logic [1:0] dir;
    } mode_t;

    function automatic mode_t mode_from_byte(input logic [BYTE_W-1:0] b);
        mode_t m;
        m.kind   = b[7:6];
        m.reload = b[4];
        m.dir    = b[3:2];
        return m;
    endfunction

    function automatic logic is_cascade(input mode_t m);
        return m.kind == KIND_CASC;
    endfunction

    function automatic logic [NCH-1:0] fixed_pick(input logic [NCH-1:0] req);
        logic [NCH-1:0] r;
        r = '0;
        for (int i = NCH - 1; i >= 0; i--) begin
            if (req[i]) begin
                r    = '0;
                r[i] = 1'b1;
            end
        end
        return r;
    endfunction
endpackage

// File: rtl/dma4_chan.sv
`timescale 1ns/1ps
module dma4_chan
    import dma4_pkg::*;
#(
    parameter bit WORD_MODE = 1'b0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              addr_we,
    input  logic              cnt_we,
    input  logic              page_we,
    input  logic              mode_we,
    input  logic              hi_sel,
    input  logic [BYTE_W-1:0] wdata,
    input  logic              step,
    output logic [AREG_W-1:0] cur_addr,
    output logic [AREG_W-1:0] cur_cnt,
    output logic [PHYS_W-1:0] phys_addr,
    output mode_t             mode,
    output logic              last
);
    logic [AREG_W-1:0] base_addr, base_cnt;
    logic [PAGE_W-1:0] page;
    logic              moving;

    assign last   = (cur_cnt == '0);
    assign moving = step && !is_cascade(mode);

    always_ff @(posedge clk) begin
        if (rst) begin
            base_addr <= '0;
            base_cnt  <= '0;
            cur_addr  <= '0;
            cur_cnt   <= '0;
            page      <= '0;
            mode      <= '0;
        end else begin
            if (moving) begin
                if (last && mode.reload) begin
                    cur_addr <= base_addr;
                    cur_cnt  <= base_cnt;
                end else begin
                    cur_addr <= cur_addr + 1'b1;
                    cur_cnt  <= cur_cnt - 1'b1;
                end
            end
            if (addr_we) begin
                if (hi_sel) begin
                    base_addr[15:8] <= wdata;
                    cur_addr[15:8]  <= wdata;
                end else begin
                    base_addr[7:0] <= wdata;
                    cur_addr[7:0]  <= wdata;
                end
            end
            if (cnt_we) begin
                if (hi_sel) begin
                    base_cnt[15:8] <= wdata;
                    cur_cnt[15:8]  <= wdata;
                end else begin
                    base_cnt[7:0] <= wdata;
                    cur_cnt[7:0]  <= wdata;
                end
            end
            if (page_we) page <= wdata;
            if (mode_we) mode <= mode_from_byte(wdata);
        end
    end

    generate
        if (WORD_MODE) begin : g_word
            assign phys_addr = {page & PAGE_W'(8'hFE), AREG_W'(0)}
                             | PHYS_W'({cur_addr, 1'b0});
        end else begin : g_byte
            assign phys_addr = {page, cur_addr};
        end
    endgenerate

    // R8: the page register only changes through its own port
    p_page_fixed_r8: assert property (@(posedge clk) disable iff (rst)
        !page_we |=> $stable(page));

    // R10: a finished non-reloading channel leaves its count at all ones
    p_cnt_wrap_r10: assert property (@(posedge clk) disable iff (rst)
        (moving && last && !mode.reload && !cnt_we) |=> (cur_cnt == '1));
endmodule

// File: rtl/dma4_arb.sv
`timescale 1ns/1ps
module dma4_arb
    import dma4_pkg::*;
(
    input  logic           clk,
    input  logic           rst,
    input  logic           flush,
    input  logic [NCH-1:0] dreq,
    input  logic [NCH-1:0] mask,
    output logic [NCH-1:0] grant,
    output logic [NCH-1:0] pending
);
    assign grant = fixed_pick(pending & ~mask);

    always_ff @(posedge clk) begin
        if (rst || flush) pending <= '0;
        else              pending <= (pending & ~grant) | dreq;
    end

    // R13: a granted request is consumed unless it is raised again
    p_consume_r13: assert property (@(posedge clk) disable iff (rst)
        ((|grant) && !flush) |=> ((pending & $past(grant) & ~$past(dreq)) == '0));
endmodule

// File: rtl/isa_dma4_ctrl.sv
`timescale 1ns/1ps
module isa_dma4_ctrl
    import dma4_pkg::*;
#(
    parameter bit WORD_MODE = 1'b0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [PORT_W-1:0] io_addr,
    input  logic              io_wr,
    input  logic              io_rd,
    input  logic [BYTE_W-1:0] io_wdata,
    output logic [BYTE_W-1:0] io_rdata,
    input  logic [NCH-1:0]    dreq,
    output logic [NCH-1:0]    dack,
    output logic [PHYS_W-1:0] mem_addr,
    output logic              mem_wr,
    output logic              tc
);
    logic              acc_chan, acc_ctl, acc_page;
    logic [CH_W-1:0]   reg_ch;
    ctl_op_e           op;
    logic              mclr_w, ptr_clr_w, stat_rd;
    logic              ff_hi;
    logic [NCH-1:0]    mask_q, tcflag_q, grant, pend;
    logic [NCH-1:0]    last_v, casc_v, reload_v, tc_ev, self_mask;
    logic [AREG_W-1:0] cur_a [NCH];
    logic [AREG_W-1:0] cur_c [NCH];
    logic [PHYS_W-1:0] phys  [NCH];
    mode_t             mode_v [NCH];
    logic [PHYS_W-1:0] sel_addr;
    logic              sel_wr;
    logic [AREG_W-1:0] rd_word;

    always_comb begin
        acc_chan  = !io_addr[4] && !io_addr[3];
        acc_ctl   = !io_addr[4] && io_addr[3];
        acc_page  = io_addr[4] && (io_addr[3:2] == 2'b00);
        reg_ch    = io_addr[2:1];
        op        = ctl_op_e'(io_addr[2:0]);
        mclr_w    = io_wr && acc_ctl && (op == OP_MCLR);
        ptr_clr_w = io_wr && acc_ctl && (op == OP_PTR_CLR);
        stat_rd   = io_rd && acc_ctl && (op == OP_STAT);
    end

    generate
        for (genvar c = 0; c < NCH; c++) begin : g_ch
            dma4_chan #(.WORD_MODE(WORD_MODE)) u_chan (
                .clk       (clk),
                .rst       (rst),
                .addr_we   (io_wr && acc_chan && !io_addr[0] && (reg_ch == CH_W'(c))),
                .cnt_we    (io_wr && acc_chan && io_addr[0] && (reg_ch == CH_W'(c))),
                .page_we   (io_wr && acc_page && (io_addr[1:0] == CH_W'(c))),
                .mode_we   (io_wr && acc_ctl && (op == OP_MODE) && (io_wdata[1:0] == CH_W'(c))),
                .hi_sel    (ff_hi),
                .wdata     (io_wdata),
                .step      (grant[c]),
                .cur_addr  (cur_a[c]),
                .cur_cnt   (cur_c[c]),
                .phys_addr (phys[c]),
                .mode      (mode_v[c]),
                .last      (last_v[c])
            );
            assign casc_v[c]   = is_cascade(mode_v[c]);
            assign reload_v[c] = mode_v[c].reload;
        end
    endgenerate

    dma4_arb u_arb (
        .clk     (clk),
        .rst     (rst),
        .flush   (mclr_w),
        .dreq    (dreq),
        .mask    (mask_q),
        .grant   (grant),
        .pending (pend)
    );

    assign tc_ev     = grant & last_v & ~casc_v;
    assign self_mask = tc_ev & ~reload_v;

    // byte pointer
    always_ff @(posedge clk) begin
        if (rst || mclr_w || ptr_clr_w)        ff_hi <= 1'b0;
        else if (acc_chan && (io_wr || io_rd)) ff_hi <= !ff_hi;
    end

    // mask bits: software first, terminal-count self-mask last
    always_ff @(posedge clk) begin
        if (rst) begin
            mask_q <= '1;
        end else begin
            if (mclr_w) mask_q <= '1;
            if (io_wr && acc_ctl) begin
                case (op)
                    OP_SMASK:      mask_q[io_wdata[1:0]] <= io_wdata[2];
                    OP_UNMASK_ALL: mask_q <= '0;
                    OP_MASK_ALL:   mask_q <= io_wdata[NCH-1:0];
                    default: ;
                endcase
            end
            for (int c = 0; c < NCH; c++) begin
                if (self_mask[c]) mask_q[c] <= 1'b1;
            end
        end
    end

    // terminal-count status flags
    always_ff @(posedge clk) begin
        if (rst || mclr_w) tcflag_q <= '0;
        else if (stat_rd)  tcflag_q <= tc_ev;
        else               tcflag_q <= tcflag_q | tc_ev;
    end

    always_comb begin
        sel_addr = '0;
        sel_wr   = 1'b0;
        for (int c = 0; c < NCH; c++) begin
            if (grant[c]) begin
                sel_addr = phys[c];
                sel_wr   = (mode_v[c].dir == DIR_IO2MEM);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            dack     <= '0;
            mem_addr <= '0;
            mem_wr   <= 1'b0;
            tc       <= 1'b0;
        end else begin
            dack     <= grant;
            mem_addr <= sel_addr;
            mem_wr   <= sel_wr;
            tc       <= |tc_ev;
        end
    end

    always_comb begin
        rd_word  = io_addr[0] ? cur_c[reg_ch] : cur_a[reg_ch];
        io_rdata = '0;
        if (acc_chan)                          io_rdata = ff_hi ? rd_word[15:8] : rd_word[7:0];
        else if (acc_ctl && (op == OP_STAT))   io_rdata = {pend, tcflag_q};
    end

    // R13: at most one acknowledge at a time
    p_dack_onehot_r13: assert property (@(posedge clk) disable iff (rst)
        $onehot0(dack));

    // R4: terminal count only rides on an acknowledge
    p_tc_with_dack_r4: assert property (@(posedge clk) disable iff (rst)
        tc |-> (|dack));

    // R5: an acknowledge never goes to a channel that was masked
    p_dack_unmasked_r5: assert property (@(posedge clk) disable iff (rst)
        (|dack) |-> (($past(mask_q) & dack) == '0));

    // R10: a channel finishing without reload is masked
    p_selfmask_r10: assert property (@(posedge clk) disable iff (rst)
        (tc && (($past(reload_v) & dack) == '0)) |-> ((mask_q & dack) == dack));
endmodule

// File: tb/isa_dma4_ctrl_tb_top.sv
`timescale 1ns/1ps
module isa_dma4_ctrl_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [4:0]  io_addr = '0;
    logic        io_wr = 1'b0, io_rd = 1'b0;
    logic [7:0]  io_wdata = '0;
    logic [7:0]  io_rdata, io_rdata_w;
    logic [3:0]  dreq = '0;
    logic [3:0]  dack, dack_w;
    logic [23:0] mem_addr, mem_addr_w;
    logic        mem_wr, mem_wr_w, tc, tc_w;
    int          checks = 0, fails = 0;

    always #4 clk = ~clk;

    isa_dma4_ctrl #(.WORD_MODE(1'b0)) dut_i (
        .clk(clk), .rst(rst), .io_addr(io_addr), .io_wr(io_wr), .io_rd(io_rd),
        .io_wdata(io_wdata), .io_rdata(io_rdata), .dreq(dreq), .dack(dack),
        .mem_addr(mem_addr), .mem_wr(mem_wr), .tc(tc));

    isa_dma4_ctrl #(.WORD_MODE(1'b1)) dut_w_i (
        .clk(clk), .rst(rst), .io_addr(io_addr), .io_wr(io_wr), .io_rd(io_rd),
        .io_wdata(io_wdata), .io_rdata(io_rdata_w), .dreq(dreq), .dack(dack_w),
        .mem_addr(mem_addr_w), .mem_wr(mem_wr_w), .tc(tc_w));

    task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", rq, act, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [7:0] d);
        @(negedge clk);
        io_addr = a; io_wdata = d; io_wr = 1'b1;
        @(negedge clk);
        io_wr = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [7:0] d);
        @(negedge clk);
        io_addr = a; io_rd = 1'b1;
        #1 d = io_rdata;
        @(negedge clk);
        io_rd = 1'b0;
    endtask

    // pulse, then move to the cycle where the acknowledge is visible
    task automatic pulse(input logic [3:0] m);
        @(negedge clk);
        dreq = m;
        @(negedge clk);
        dreq = '0;
        @(negedge clk);
    endtask

    task automatic t_reset;
        logic [7:0] d;
        chk("R1 dack", dack, 0);
        chk("R1 tc", tc, 0);
        chk("R1 mem_addr", mem_addr, 0);
        rd(5'h08, d); chk("R1 status", d, 8'h00);
        pulse(4'b0001);
        chk("R1/R5 masked no dack", dack, 0);
        rd(5'h08, d); chk("R14 pending visible", d, 8'h10);
        wr(5'h0D, 8'h00);
        rd(5'h08, d); chk("R12 pending cleared", d, 8'h00);
    endtask

    task automatic t_pointer;
        logic [7:0] d;
        wr(5'h00, 8'h34); wr(5'h00, 8'h12);
        rd(5'h00, d); chk("R2 addr lo", d, 8'h34);
        rd(5'h00, d); chk("R2 addr hi", d, 8'h12);
        wr(5'h02, 8'hAA);
        wr(5'h0C, 8'h5C);
        wr(5'h02, 8'h55); wr(5'h02, 8'h66);
        rd(5'h02, d); chk("R3 lo after clear", d, 8'h55);
        rd(5'h02, d); chk("R3 hi after clear", d, 8'h66);
    endtask

    task automatic t_byte_xfer;
        logic [7:0] d;
        wr(5'h10, 8'h35);
        wr(5'h00, 8'h34); wr(5'h00, 8'h12);
        wr(5'h01, 8'h02); wr(5'h01, 8'h00);
        wr(5'h0B, 8'h44);
        wr(5'h0A, 8'h00);
        pulse(4'b0001);
        chk("R13 dack ch0", dack, 4'b0001);
        chk("R8 addr 1", mem_addr, 24'h351234);
        chk("R9 word addr", mem_addr_w, 24'h342468);
        chk("R7 mem_wr io2mem", mem_wr, 1);
        chk("R4 no tc 1", tc, 0);
        pulse(4'b0001);
        chk("R8 addr 2", mem_addr, 24'h351235);
        chk("R4 no tc 2", tc, 0);
        pulse(4'b0001);
        chk("R8 addr 3", mem_addr, 24'h351236);
        chk("R4 tc on third", tc, 1);
        rd(5'h08, d); chk("R10 status flag", d, 8'h01);
        rd(5'h08, d); chk("R14 flag cleared by read", d, 8'h00);
        rd(5'h01, d); chk("R10 residue lo", d, 8'hFF);
        rd(5'h01, d); chk("R10 residue hi", d, 8'hFF);
        pulse(4'b0001);
        chk("R10 self-masked", dack, 0);
        rd(5'h00, d); chk("R12 addr before clear", d, 8'h37);
        wr(5'h0D, 8'h00);
        rd(5'h00, d); chk("R12 pointer cleared", d, 8'h37);
        rd(5'h00, d); chk("R12 addr kept", d, 8'h12);
        rd(5'h08, d); chk("R12 status cleared", d, 8'h00);
    endtask

    task automatic t_wrap_reload;
        logic [7:0] d;
        wr(5'h12, 8'h07);
        wr(5'h04, 8'hFF); wr(5'h04, 8'hFF);
        wr(5'h05, 8'h01); wr(5'h05, 8'h00);
        wr(5'h0B, 8'h5A);
        wr(5'h0A, 8'h02);
        pulse(4'b0100);
        chk("R8 start", mem_addr, 24'h07FFFF);
        chk("R7 mem_wr mem2io", mem_wr, 0);
        chk("R4 no tc", tc, 0);
        pulse(4'b0100);
        chk("R8 wrap in page", mem_addr, 24'h070000);
        chk("R11 tc", tc, 1);
        pulse(4'b0100);
        chk("R11 still unmasked", dack, 4'b0100);
        chk("R11 reloaded addr", mem_addr, 24'h07FFFF);
        rd(5'h04, d); chk("R11 cur addr lo", d, 8'h00);
        rd(5'h04, d); chk("R11 cur addr hi", d, 8'h00);
        rd(5'h05, d); chk("R11 cur cnt lo", d, 8'h00);
        wr(5'h0D, 8'h00);
    endtask

    task automatic t_priority;
        wr(5'h0E, 8'h00);
        pulse(4'b1110);
        chk("R13 first ch1", dack, 4'b0010);
        @(negedge clk); chk("R13 second ch2", dack, 4'b0100);
        @(negedge clk); chk("R13 third ch3", dack, 4'b1000);
        @(negedge clk); chk("R13 idle", dack, 4'b0000);
        wr(5'h0F, 8'h0B);
        pulse(4'b1111);
        chk("R6 only ch2", dack, 4'b0100);
        @(negedge clk); chk("R6 masked rest", dack, 4'b0000);
        wr(5'h0D, 8'h00);
    endtask

    task automatic t_cascade;
        logic [7:0] a0, a1, d;
        wr(5'h0B, 8'hC1);
        wr(5'h0A, 8'h01);
        rd(5'h02, a0); rd(5'h02, a1);
        pulse(4'b0010);
        chk("R7 cascade dack", dack, 4'b0010);
        chk("R7 cascade no tc", tc, 0);
        rd(5'h02, d); chk("R7 cascade addr lo kept", d, a0);
        rd(5'h02, d); chk("R7 cascade addr hi kept", d, a1);
    endtask

    initial begin
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_pointer();
        t_byte_xfer();
        t_wrap_reload();
        t_priority();
        t_cascade();
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule